// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This controller manages thread switching in a pipeline that runs one hardware thread at a time. The running thread keeps the front end to itself and fetches every cycle, with no interleaving. A short stall only holds fetch for that cycle. When the running thread reports a long-latency event, such as a miss in the second-level cache, the controller takes the pipeline through a fixed switch sequence. First it drains the pipeline. Then it strobes context save for the outgoing thread and context restore for the incoming one. After one quiet refill cycle, fetch resumes for the new thread.

A thread that reported a long-latency event is parked until its own miss-completion pulse arrives. The incoming thread is the first eligible thread in increasing index order after the current one, wrapping around, and the current thread is considered last. A thread is eligible when its ready flag is high and it is not parked. If no thread is eligible when the save phase ends, the controller waits with every strobe low until one becomes eligible.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: During and after reset, the controller is in the waiting phase with every strobe and fetch low and `active_tid_o` equal to NUM_THREADS-1. It therefore starts with the lowest-numbered eligible thread.
- R2: In the run phase, with `long_stall_i` low, `fetch_en_o` is high (when `short_stall_i` is low), the active thread does not change and no switch starts.
- R3: A short stall (`short_stall_i` high in the run phase) drops `fetch_en_o` in that same cycle only and never starts a switch.
- R4: `long_stall_i` high in the run phase makes `flush_o` rise on the next cycle and stay high for exactly PIPE_DEPTH cycles.
- R5: The flush is followed at once by SAVE_CYCLES cycles of `ctx_save_o`.
- R6: If a thread is eligible in the last save cycle, `ctx_restore_o` is high for RESTORE_CYCLES cycles, with `active_tid_o` already showing the new thread. Then comes one refill cycle with all strobes and fetch low, and then the run phase.
- R7: The incoming thread is the first eligible index after the current one, in the order cur+1, cur+2, ... modulo NUM_THREADS, with the current thread last.
- R8: A thread is eligible only when `thread_ready_i[i]` is high and it is not parked. The thread that raised `long_stall_i` is parked from that cycle until a `miss_done_i[i]` pulse.
- R9: With no eligible thread, the controller waits with all strobes and fetch low and `active_tid_o` unchanged. In the cycle after a thread becomes eligible, the restore phase begins.
- R10: `fetch_en_o` is low in every phase except run, and `long_stall_i` has no effect outside the run phase.
- R11: At most one of `fetch_en_o`, `flush_o`, `ctx_save_o` and `ctx_restore_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_stall_i | input | 1 | Long-latency event from the running thread |
| short_stall_i | input | 1 | Short stall; holds fetch for this cycle only |
| thread_ready_i | input | NUM_THREADS | Per-thread ready flags |
| miss_done_i | input | NUM_THREADS | Per-thread miss-completion pulses |
| active_tid_o | output | TID_W | Thread that owns the pipeline |
| flush_o | output | 1 | Pipeline drain request |
| fetch_en_o | output | 1 | Fetch enable |
| ctx_save_o | output | 1 | Context save strobe |
| ctx_restore_o | output | 1 | Context restore strobe |

## Verification
The hardest state to reach from the ports is the wait with no eligible thread. It needs every ready thread to be parked, or every other flag low, exactly when the save phase ends. A directed sequence gets there by lowering every ready flag except the running thread's, raising a long stall and withholding the completion pulse. It then releases the pulse to check the resume cycle. Long runs of seeded random stalls, ready changes and completion pulses cover the rest: selection with wraparound, parked threads being skipped, and stalls arriving during flush or save.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_FLUSH   = 3'd2,
    ST_SAVE    = 3'd3,
    ST_RESTORE = 3'd4,
    ST_REFILL  = 3'd5
  } cgmt_state_e;
endpackage

// File: rtl/cgmt_wait_track.sv
// Per-thread parked flags; a thread becomes eligible again on its completion pulse.
module cgmt_wait_track #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   park_en_i,
  input  logic [TID_W-1:0]       park_tid_i,
  input  logic [NUM_THREADS-1:0] miss_done_i,
  input  logic [NUM_THREADS-1:0] thread_ready_i,
  output logic [NUM_THREADS-1:0] eligible_o
);
  logic [NUM_THREADS-1:0] parked_q;

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
    logic park_hit;
    logic upd_en;
    logic parked_d;

    assign park_hit = park_en_i && (park_tid_i == TID_W'(i));
    assign upd_en   = park_hit || miss_done_i[i];
    assign parked_d = park_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        parked_q[i] <= 1'b0;
      end else if (upd_en) begin
        parked_q[i] <= parked_d;
      end
    end

    assign eligible_o[i] = thread_ready_i[i] && !parked_q[i];
  end
endmodule

// File: rtl/cgmt_rr_pick.sv
// Round-robin choice: first eligible thread after the current one, current last.
module cgmt_rr_pick #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [TID_W-1:0]       cur_tid_i,
  input  logic [NUM_THREADS-1:0] eligible_i,
  output logic                   found_o,
  output logic [TID_W-1:0]       pick_tid_o
);
  logic [TID_W-1:0] idx;

  always_comb begin
    found_o    = 1'b0;
    pick_tid_o = cur_tid_i;
    idx        = cur_tid_i;
    // scan from farthest to nearest so the nearest hit wins
    for (int k = NUM_THREADS; k >= 1; k--) begin
      idx = TID_W'((int'(cur_tid_i) + k) % NUM_THREADS);
      if (eligible_i[idx]) begin
        found_o    = 1'b1;
        pick_tid_o = idx;
      end
    end
  end
endmodule

// File: rtl/cgmt_fsm.sv
// Switch sequencer: run -> flush -> save -> (wait) -> restore -> refill -> run.
module cgmt_fsm
  import cgmt_pkg::*;
#(
  parameter int NUM_THREADS    = 4,
  parameter int PIPE_DEPTH     = 5,
  parameter int SAVE_CYCLES    = 3,
  parameter int RESTORE_CYCLES = 3,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int MAX_A = (PIPE_DEPTH > SAVE_CYCLES) ? PIPE_DEPTH : SAVE_CYCLES,
  localparam int MAX_D = (MAX_A > RESTORE_CYCLES) ? MAX_A : RESTORE_CYCLES,
  localparam int CNT_W = $clog2(MAX_D + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             long_stall_i,
  input  logic             found_i,
  input  logic [TID_W-1:0] pick_tid_i,
  output cgmt_state_e      state_o,
  output logic [TID_W-1:0] tid_o,
  output logic             park_o
);
  cgmt_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TID_W-1:0] tid_q, tid_d;
  logic             cnt_zero;
  logic             upd_en;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tid_d   = tid_q;
    park_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (found_i) begin
          state_d = ST_RESTORE;
          cnt_d   = CNT_W'(RESTORE_CYCLES - 1);
          tid_d   = pick_tid_i;
        end
      end
      ST_RUN: begin
        if (long_stall_i) begin
          park_o  = 1'b1;
          state_d = ST_FLUSH;
          cnt_d   = CNT_W'(PIPE_DEPTH - 1);
        end
      end
      ST_FLUSH: begin
        if (cnt_zero) begin
          state_d = ST_SAVE;
          cnt_d   = CNT_W'(SAVE_CYCLES - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_SAVE: begin
        if (cnt_zero) begin
          if (found_i) begin
            state_d = ST_RESTORE;
            cnt_d   = CNT_W'(RESTORE_CYCLES - 1);
            tid_d   = pick_tid_i;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_RESTORE: begin
        if (cnt_zero) begin
          state_d = ST_REFILL;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_REFILL: begin
        state_d = ST_RUN;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign upd_en = (state_d != state_q) || (cnt_d != cnt_q) || (tid_d != tid_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tid_q   <= TID_W'(NUM_THREADS - 1);
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tid_q   <= tid_d;
    end
  end

  assign state_o = state_q;
  assign tid_o   = tid_q;
endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl
  import cgmt_pkg::*;
#(
  parameter int NUM_THREADS    = 4,
  parameter int PIPE_DEPTH     = 5,
  parameter int SAVE_CYCLES    = 3,
  parameter int RESTORE_CYCLES = 3,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   long_stall_i,
  input  logic                   short_stall_i,
  input  logic [NUM_THREADS-1:0] thread_ready_i,
  input  logic [NUM_THREADS-1:0] miss_done_i,
  output logic [TID_W-1:0]       active_tid_o,
  output logic                   flush_o,
  output logic                   fetch_en_o,
  output logic                   ctx_save_o,
  output logic                   ctx_restore_o
);
  cgmt_state_e            state;
  logic [TID_W-1:0]       tid;
  logic                   park;
  logic [NUM_THREADS-1:0] eligible;
  logic                   found;
  logic [TID_W-1:0]       pick_tid;

  cgmt_wait_track #(.NUM_THREADS(NUM_THREADS)) u_wait (
    .clk            (clk),
    .rst_n          (rst_n),
    .park_en_i      (park),
    .park_tid_i     (tid),
    .miss_done_i    (miss_done_i),
    .thread_ready_i (thread_ready_i),
    .eligible_o     (eligible)
  );

  cgmt_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
    .cur_tid_i  (tid),
    .eligible_i (eligible),
    .found_o    (found),
    .pick_tid_o (pick_tid)
  );

  cgmt_fsm #(
    .NUM_THREADS    (NUM_THREADS),
    .PIPE_DEPTH     (PIPE_DEPTH),
    .SAVE_CYCLES    (SAVE_CYCLES),
    .RESTORE_CYCLES (RESTORE_CYCLES)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .long_stall_i (long_stall_i),
    .found_i      (found),
    .pick_tid_i   (pick_tid),
    .state_o      (state),
    .tid_o        (tid),
    .park_o       (park)
  );

  assign active_tid_o  = tid;
  assign fetch_en_o    = (state == ST_RUN) && !short_stall_i;
  assign flush_o       = (state == ST_FLUSH);
  assign ctx_save_o    = (state == ST_SAVE);
  assign ctx_restore_o = (state == ST_RESTORE);
endmodule

// File: rtl/cgmt_switch_ctrl_chk.sv
module cgmt_switch_ctrl_chk
  import cgmt_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int PIPE_DEPTH  = 5,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             long_stall_i,
  input cgmt_state_e      state,
  input logic [TID_W-1:0] active_tid_o,
  input logic             flush_o,
  input logic             fetch_en_o,
  input logic             ctx_save_o,
  input logic             ctx_restore_o
);
  logic        run_st;
  logic [15:0] flush_len;

  assign run_st = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_len <= '0;
    end else if (flush_o) begin
      if (flush_len != 16'hFFFF) flush_len <= flush_len + 16'd1;
    end else begin
      flush_len <= '0;
    end
  end

  AST_STALL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st && long_stall_i) |=> flush_o); // R4
  AST_FLUSH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_o) |-> (int'(flush_len) == PIPE_DEPTH)); // R4
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st && !long_stall_i) |=> (run_st && $stable(active_tid_o))); // R2
  AST_SAVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_o) |-> ctx_save_o); // R5
  AST_TID_AT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_restore_o |=> ($stable(active_tid_o) || ctx_restore_o)); // R6
  AST_FETCH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en_o |-> run_st); // R10
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_en_o, flush_o, ctx_save_o, ctx_restore_o})); // R11
  AST_TID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(active_tid_o) < NUM_THREADS); // R7
endmodule

bind cgmt_switch_ctrl cgmt_switch_ctrl_chk #(
  .NUM_THREADS (NUM_THREADS),
  .PIPE_DEPTH  (PIPE_DEPTH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .long_stall_i  (long_stall_i),
  .state         (state),
  .active_tid_o  (active_tid_o),
  .flush_o       (flush_o),
  .fetch_en_o    (fetch_en_o),
  .ctx_save_o    (ctx_save_o),
  .ctx_restore_o (ctx_restore_o)
);

// File: tb/cgmt_switch_ctrl_test.sv
`timescale 1ns/1ps
module cgmt_switch_ctrl_test;
  localparam int N  = 4;
  localparam int PD = 5;
  localparam int SV = 3;
  localparam int RS = 3;
  localparam int TW = 2;

  logic          clk;
  logic          rst_n;
  logic          long_stall;
  logic          short_stall;
  logic [N-1:0]  ready;
  logic [N-1:0]  done;
  logic [TW-1:0] tid;
  logic          flush, fetch_en, save, restore;

  int errors;
  int checks;
  bit finished;

  // bench reference: 0 wait, 1 run, 2 flush, 3 save, 4 restore, 5 refill
  int           m_state;
  int           m_cnt;
  int           m_tid;
  logic [N-1:0] m_park;

  cgmt_switch_ctrl #(
    .NUM_THREADS(N), .PIPE_DEPTH(PD), .SAVE_CYCLES(SV), .RESTORE_CYCLES(RS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .long_stall_i(long_stall), .short_stall_i(short_stall),
    .thread_ready_i(ready), .miss_done_i(done), .active_tid_o(tid),
    .flush_o(flush), .fetch_en_o(fetch_en), .ctx_save_o(save), .ctx_restore_o(restore)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int pick_next(int cur, logic [N-1:0] el);
    for (int k = 1; k <= N; k++) begin
      if (el[(cur + k) % N]) return (cur + k) % N;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_tid = N - 1; m_park = '0;
    end else begin
      logic [N-1:0] el;
      logic [N-1:0] setm;
      int p;
      el   = ready & ~m_park;
      setm = '0;
      p    = pick_next(m_tid, el);
      case (m_state)
        0: if (p >= 0) begin m_state = 4; m_cnt = RS; m_tid = p; end
        1: if (long_stall) begin setm[m_tid] = 1'b1; m_state = 2; m_cnt = PD; end
        2: begin m_cnt--; if (m_cnt == 0) begin m_state = 3; m_cnt = SV; end end
        3: begin
          m_cnt--;
          if (m_cnt == 0) begin
            if (p >= 0) begin m_state = 4; m_cnt = RS; m_tid = p; end
            else m_state = 0;
          end
        end
        4: begin m_cnt--; if (m_cnt == 0) m_state = 5; end
        default: m_state = 1;
      endcase
      // a state's count is loaded as its length and reaches 0 on its last cycle
      if (m_state == 2 || m_state == 3 || m_state == 4) begin
        if (m_cnt == PD && m_state == 2) m_cnt = PD;
      end
      m_park = (m_park & ~done) | setm;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    string fr;
    fr = (m_state == 1) ? (short_stall ? "R3" : "R2") : "R10";
    check(fr, "fetch_en", int'(fetch_en), int'(m_state == 1 && !short_stall));
    check("R4", "flush", int'(flush), int'(m_state == 2));
    check("R5", "save", int'(save), int'(m_state == 3));
    check("R6", "restore", int'(restore), int'(m_state == 4));
    check("R7", "active_tid", int'(tid), m_tid);
    check("R11", "strobe count", $countones({fetch_en, flush, save, restore}) <= 1, 1);
    if (m_state == 0)
      check("R9", "wait strobes", int'({fetch_en, flush, save, restore}), 0);
  endtask

  task automatic step(logic ls, logic ss, logic [N-1:0] rd, logic [N-1:0] dn);
    @(negedge clk);
    long_stall = ls; short_stall = ss; ready = rd; done = dn;
    #2;
    check_all();
  endtask

  initial begin
    int unsigned seed;
    logic [N-1:0] rd;
    int t;
    errors = 0; checks = 0; finished = 0;
    rst_n = 1'b1; long_stall = 0; short_stall = 0; ready = 4'b0110; done = '0;
    seed = $urandom(32'd20240611);
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "tid in reset", int'(tid), N - 1);
    check("R1", "strobes in reset", int'({fetch_en, flush, save, restore}), 0);
    rst_n = 1'b1;
    #2 check_all();
    step(0, 0, 4'b0110, 0);
    step(0, 0, 4'b0110, 0);
    // R1: lowest eligible from index 0 is thread 1
    check("R1", "first thread", int'(tid), 1);
    for (int i = 0; i < 8; i++) step(0, 0, 4'b0110, 0);
    check("R2", "running fetch", int'(fetch_en), 1);

    // random mix of stalls, ready changes and completions
    rd = '1;
    for (int i = 0; i < 6000; i++) begin
      logic [N-1:0] dn;
      if ($urandom % 150 == 0) rd = N'($urandom) | N'(1 << ($urandom % N));
      for (int j = 0; j < N; j++) dn[j] = ($urandom % 10 == 0);
      step(($urandom % 14 == 0), ($urandom % 4 == 0), rd, dn);
    end

    // directed: only the running thread ready, park it, nobody eligible
    for (int i = 0; i < 60 && m_state != 1; i++) step(0, 0, '1, '1);
    t = m_tid;
    step(1, 0, N'(1 << t), 0);
    for (int i = 0; i < PD + SV + 12; i++) step(0, 0, N'(1 << t), 0);
    check("R9", "waiting strobes", int'({fetch_en, flush, save, restore}), 0);
    check("R9", "tid held while waiting", int'(tid), t);
    step(1, 0, N'(1 << t), 0);
    check("R10", "stall ignored while waiting", int'(flush), 0);
    step(0, 0, N'(1 << t), N'(1 << t));
    step(0, 0, N'(1 << t), 0);
    step(0, 0, N'(1 << t), 0);
    check("R8", "restore after completion", int'(restore), 1);
    check("R8", "same thread resumes", int'(tid), t);
    for (int i = 0; i < RS + 2; i++) step(0, 0, '1, 0);
    check("R6", "run after refill", int'(fetch_en), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule